// File: doc/BRIEF.md
# Synchronizable Clock Divider with Half-Cycle Start Delay

This block divides a fast input clock by an even ratio and lets the phase of the divided output be placed in half-cycle steps of the fast clock. A sync pulse forces the output low and clears all counting. When sync is released, the block waits a programmed number of fast-clock cycles and then starts the divided clock. The delay is an integer cycle count, reduced by half a cycle when a half-step flag is set.

The half-cycle step is produced by a falling-edge retiming stage. The rising-edge logic launches the output one full cycle early, and the falling-edge stage delays it by half a cycle. Several dividers synced by the same pulse keep a fixed phase relation that this delay sets. For a divide-by-10 output, each half-cycle step of delay moves the output by 18 degrees.

Top module: `clkdly_halfstep`

## Requirements
- R1: While reset is low and after reset until the first sync release, `clk_o` and `running_o` are low. `running_o` low always implies `clk_o` low.
- R2: A cycle in which `sync_i` is sampled high forces `clk_o` and `running_o` low by the next rising edge of `clk`. Both stay low while `sync_i` stays high.
- R3: Call T0 the first rising edge of `clk` at which `sync_i` is sampled low after a sync. The first rising edge of `clk_o` comes N - 0.5*H fast-clock cycles after T0. N is `dly_int_i` and H is `dly_half_i`.
- R4: When `dly_int_i` is below 5, the delay is clamped to 4.5 cycles, whatever the value of `dly_half_i`.
- R5: When the half-step flag is set, the first output edge and all later output edges fall on falling edges of `clk`. When it is clear, they all fall on rising edges.
- R6: The output is high for ratio/2 cycles and low for ratio/2 cycles. The ratio is `ratio_i` with bit 0 forced to 0, and a result below 2 is treated as 2.
- R7: `running_o` rises together with the first rising edge of `clk_o`. It then stays high until the next sync or reset.
- R8: Ratio and delay inputs are captured only while `sync_i` or reset is active. Changing them while the output runs does not alter its timing.
- R9: With ratio 10, delays 4.5 and 14.5 give the same output phase, and 14.5 starts one output period later. The 20 half-cycle steps from 4.5 to 14.0 give 20 distinct phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock; both edges are used |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Active-high sync; holds the output off and restarts the delay |
| ratio_i | input | RATIO_W | Divide ratio (even, minimum 2) |
| dly_int_i | input | DLY_W | Integer start delay in fast-clock cycles |
| dly_half_i | input | 1 | Subtract half a cycle from the start delay |
| clk_o | output | 1 | Divided clock |
| running_o | output | 1 | High from the first output rising edge until sync or reset |

## Verification
The bench works in half-cycle units. It samples `clk_o` at quarter-period points, midway between edges, so every output edge falls strictly between two samples. After the edge T0, the first rising output edge is due 2N - H half-cycles later: 2N for the rising-edge register path, less one for the early launch that the falling-edge stage then delays by one half-cycle. The bench counts samples from T0 and compares the count with that figure exactly. The suppression by sync is due one rising edge after the edge that samples `sync_i`, and the bench checks it two edges after it raises sync. The high and low widths are due ratio half-cycles apart, and the bench counts them the same way.

// File: rtl/clkdly_pkg.sv
// Package for the half-step clock divider: shared state type and limits.
package clkdly_pkg;

    // Launch controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // after reset, waiting for first sync
        ST_WAIT = 2'd1,   // counting the start delay
        ST_RUN  = 2'd2    // output toggling
    } launch_state_t;

    // Smallest integer delay field accepted without clamping
    localparam int MIN_DLY_INT = 5;

    // Smallest divide ratio
    localparam int MIN_RATIO = 2;

endpackage

// File: rtl/cdh_cfg_latch.sv
// Captures and sanitises ratio and delay settings while sync or reset
// is active. Assumes DLY_W >= 4 so the minimum delay is representable.
// Outputs: half of the even ratio, the rising-edge launch count and the
// half-step select used by the output stage.
module cdh_cfg_latch
    import clkdly_pkg::*;
#(
    parameter int RATIO_W = 8,
    parameter int DLY_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [DLY_W-1:0]   dly_int_i,
    input  logic               dly_half_i,
    output logic [RATIO_W-1:0] half_ratio_o,
    output logic [DLY_W-1:0]   start_o,
    output logic               half_o
);

    localparam logic [RATIO_W-1:0] RATIO_FLOOR = RATIO_W'(MIN_RATIO);
    localparam logic [DLY_W-1:0]   DLY_FLOOR   = DLY_W'(MIN_DLY_INT);

    logic [RATIO_W-1:0] ratio_even;
    logic [RATIO_W-1:0] ratio_ok;
    logic [DLY_W-1:0]   dly_ok;
    logic               half_ok;
    logic [DLY_W-1:0]   start_calc;

    // Force the ratio even and raise it to the floor
    always_comb begin
        ratio_even = {ratio_i[RATIO_W-1:1], 1'b0};
        ratio_ok   = (ratio_even < RATIO_FLOOR) ? RATIO_FLOOR : ratio_even;
    end

    // Clamp the delay to 4.5 cycles and derive the rising-edge launch count
    always_comb begin
        if (dly_int_i < DLY_FLOOR) begin
            dly_ok  = DLY_FLOOR;
            half_ok = 1'b1;
        end else begin
            dly_ok  = dly_int_i;
            half_ok = dly_half_i;
        end
        start_calc = half_ok ? (dly_ok - DLY_W'(1)) : dly_ok;
    end

    // Register the sanitised settings only while sync or reset is active
    always_ff @(posedge clk) begin
        if (!rst_n || sync_i) begin
            half_ratio_o <= ratio_ok >> 1;
            start_o      <= start_calc;
            half_o       <= half_ok;
        end
    end

endmodule

// File: rtl/cdh_launch_div.sv
// Rising-edge launch controller and divider. After sync is released it
// counts start_i edges, then drives the divided clock high and toggles it
// every half_ratio_i edges. Assumes half_ratio_i >= 1 and settings that
// stay constant outside sync.
module cdh_launch_div
    import clkdly_pkg::*;
#(
    parameter int RATIO_W = 8,
    parameter int DLY_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_i,
    input  logic [DLY_W-1:0]   start_i,
    input  logic [RATIO_W-1:0] half_ratio_i,
    output logic               div_o,
    output logic               run_o
);

    launch_state_t      state;
    logic [DLY_W-1:0]   wait_cnt;
    logic [RATIO_W-1:0] tog_cnt;

    // Delay count, launch and divided-clock toggling on the rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
            tog_cnt  <= '0;
            div_o    <= 1'b0;
            run_o    <= 1'b0;
        end else if (sync_i) begin
            state    <= ST_WAIT;
            wait_cnt <= '0;
            tog_cnt  <= '0;
            div_o    <= 1'b0;
            run_o    <= 1'b0;
        end else begin
            case (state)
                ST_WAIT: begin
                    if (wait_cnt == start_i) begin
                        state   <= ST_RUN;
                        div_o   <= 1'b1;
                        run_o   <= 1'b1;
                        tog_cnt <= '0;
                    end else begin
                        wait_cnt <= wait_cnt + DLY_W'(1);
                    end
                end
                ST_RUN: begin
                    if (tog_cnt == half_ratio_i - RATIO_W'(1)) begin
                        div_o   <= ~div_o;
                        tog_cnt <= '0;
                    end else begin
                        tog_cnt <= tog_cnt + RATIO_W'(1);
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/cdh_half_shift.sv
// Output stage. Retimes the rising-edge divided clock and run flag on the
// falling edge and selects that copy when the half step is enabled, which
// shifts every output edge half a fast-clock cycle later. Assumes half_i
// changes only while the rising-edge signals are held low.
module cdh_half_shift (
    input  logic clk,
    input  logic rst_n,
    input  logic half_i,
    input  logic div_i,
    input  logic run_i,
    output logic clk_o,
    output logic run_o
);

    logic div_neg;
    logic run_neg;

    // Falling-edge copies of the divided clock and run flag
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            div_neg <= 1'b0;
            run_neg <= 1'b0;
        end else begin
            div_neg <= div_i;
            run_neg <= run_i;
        end
    end

    // Pick the rising-edge or falling-edge copy
    always_comb begin
        clk_o = half_i ? div_neg : div_i;
        run_o = half_i ? run_neg : run_i;
    end

endmodule

// File: rtl/clkdly_halfstep.sv
// Top: synchronizable even-ratio clock divider with a start delay in
// half fast-clock steps. Settings are captured during sync, the launch
// controller counts the delay on rising edges, and the output stage adds
// the half step from the falling edge.
module clkdly_halfstep #(
    parameter int RATIO_W = 8,
    parameter int DLY_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [DLY_W-1:0]   dly_int_i,
    input  logic               dly_half_i,
    output logic               clk_o,
    output logic               running_o
);

    logic [RATIO_W-1:0] half_ratio;
    logic [DLY_W-1:0]   start_cnt;
    logic               half_sel;
    logic               div_pos;
    logic               run_pos;

    cdh_cfg_latch #(.RATIO_W(RATIO_W), .DLY_W(DLY_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_i       (sync_i),
        .ratio_i      (ratio_i),
        .dly_int_i    (dly_int_i),
        .dly_half_i   (dly_half_i),
        .half_ratio_o (half_ratio),
        .start_o      (start_cnt),
        .half_o       (half_sel)
    );

    cdh_launch_div #(.RATIO_W(RATIO_W), .DLY_W(DLY_W)) u_launch (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_i       (sync_i),
        .start_i      (start_cnt),
        .half_ratio_i (half_ratio),
        .div_o        (div_pos),
        .run_o        (run_pos)
    );

    cdh_half_shift u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .half_i (half_sel),
        .div_i  (div_pos),
        .run_i  (run_pos),
        .clk_o  (clk_o),
        .run_o  (running_o)
    );

endmodule

// File: rtl/cdh_checker.sv
// Port-level checks for clkdly_halfstep, attached by bind.
module cdh_checker (
    input logic clk,
    input logic rst_n,
    input logic sync_i,
    input logic clk_o,
    input logic running_o
);

    // R2
    sync_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (!clk_o && !running_o));

    // R7
    run_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running_o) |-> clk_o);

    // R7
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && !sync_i) |=> running_o);

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |-> !clk_o);

endmodule

bind clkdly_halfstep cdh_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (sync_i),
    .clk_o     (clk_o),
    .running_o (running_o)
);

// File: tb/sim_clkdly_halfstep.sv
module sim_clkdly_halfstep;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int RATIO_W = 8;
    localparam int DLY_W   = 5;
    localparam int NVEC    = 9;

    // Columns: ratio, dly_int, half, expected start (half-cycles), expected width (half-cycles)
    localparam int VTAB [0:NVEC-1][0:4] = '{
        '{10, 14, 1, 27, 10},   // R3 13.5
        '{10, 14, 0, 28, 10},   // R3 14.0
        '{10,  5, 1,  9, 10},   // R3 minimum 4.5
        '{10,  3, 0,  9, 10},   // R4 clamp
        '{10,  4, 1,  9, 10},   // R4 clamp from 3.5
        '{ 4,  6, 0, 12,  4},   // R6 ratio 4
        '{ 3,  7, 1, 13,  2},   // R6 odd ratio -> 2
        '{ 0,  8, 0, 16,  2},   // R6 zero ratio -> 2
        '{ 2, 31, 1, 61,  2}    // R3 largest delay
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sync_i = 1'b0;
    logic [RATIO_W-1:0] ratio_i = 8'd10;
    logic [DLY_W-1:0]   dly_int_i = 5'd14;
    logic               dly_half_i = 1'b0;
    logic               clk_o;
    logic               running_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    clkdly_halfstep #(.RATIO_W(RATIO_W), .DLY_W(DLY_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (sync_i),
        .ratio_i    (ratio_i),
        .dly_int_i  (dly_int_i),
        .dly_half_i (dly_half_i),
        .clk_o      (clk_o),
        .running_o  (running_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Waits in half-cycle steps from a quarter point until clk_o equals lvl
    task automatic wait_level(input logic lvl, output int steps);
        steps = 0;
        while (clk_o !== lvl && steps < 200) begin
            #5;
            steps++;
        end
        if (steps >= 200) steps = -1;
    endtask

    // Applies settings with a sync pulse; returns at the edge T0
    task automatic do_sync(input int r, input int d, input int hf);
        @(posedge clk);
        #2;
        ratio_i    = RATIO_W'(r);
        dly_int_i  = DLY_W'(d);
        dly_half_i = hf[0];
        sync_i     = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #2;
        check(clk_o == 1'b0 && running_o == 1'b0, "R2 sync off",
              int'({clk_o, running_o}), 0);
        sync_i = 1'b0;
        @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finished");
        report();
        $finish;
    end

    initial begin
        int h;
        int w;
        int h_lo;
        int h_hi;
        logic [19:0] mask;

        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check(clk_o == 1'b0 && running_o == 1'b0, "R1 in reset",
              int'({clk_o, running_o}), 0);
        rst_n = 1'b1;
        repeat (40) @(posedge clk);
        #2;
        check(clk_o == 1'b0 && running_o == 1'b0, "R1 idle before sync",
              int'({clk_o, running_o}), 0);

        // Vector table: start delay, running flag, high and low widths
        for (int i = 0; i < NVEC; i++) begin
            do_sync(VTAB[i][0], VTAB[i][1], VTAB[i][2]);
            #2.5;
            wait_level(1'b1, h);
            check(h == VTAB[i][3], "R3/R4/R5 start delay", h, VTAB[i][3]);
            check(running_o == 1'b1, "R7 running at first edge", int'(running_o), 1);
            wait_level(1'b0, w);
            check(w == VTAB[i][4], "R6 high width", w, VTAB[i][4]);
            wait_level(1'b1, w);
            check(w == VTAB[i][4], "R6 low width", w, VTAB[i][4]);
            check(running_o == 1'b1, "R7 running held", int'(running_o), 1);
        end

        // R9: sweep 4.5 .. 14.5 in half steps at ratio 10
        mask = '0;
        h_lo = -1;
        h_hi = -1;
        for (int k = 9; k <= 29; k++) begin
            do_sync(10, (k + 1) / 2, k % 2);
            #2.5;
            wait_level(1'b1, h);
            check(h == k, "R3 sweep delay", h, k);
            if (h >= 0 && k <= 28) mask[h % 20] = 1'b1;
            if (k == 9)  h_lo = h;
            if (k == 29) h_hi = h;
        end
        check(mask == 20'hFFFFF, "R9 all phases", int'(mask), 20'hFFFFF);
        check(h_lo >= 0 && h_hi >= 0 && (h_lo % 20) == (h_hi % 20),
              "R9 same phase 4.5/14.5", h_hi % 20, h_lo % 20);
        check(h_hi - h_lo == 20, "R9 longer off time", h_hi - h_lo, 20);

        // R8: settings changed while running have no effect
        do_sync(10, 6, 0);
        #2.5;
        wait_level(1'b1, h);
        check(h == 12, "R8 start", h, 12);
        ratio_i    = 8'd4;
        dly_int_i  = 5'd20;
        dly_half_i = 1'b1;
        wait_level(1'b0, w);
        check(w == 10, "R8 high width kept", w, 10);
        wait_level(1'b1, w);
        check(w == 10, "R8 low width kept", w, 10);

        // R2: sync during a run stops the output; new settings then apply
        do_sync(4, 20, 1);
        #2.5;
        wait_level(1'b1, h);
        check(h == 39, "R8 applied at next sync", h, 39);

        report();
        $finish;
    end

endmodule